// File: doc/BRIEF.md
# MAC Statistics Counter Bank with Snapshot Read-Out

This block holds one wide event counter per MAC receive and transmit statistic: good octets, unicast, multicast and broadcast frames, pause frames, FCS errors, internal MAC errors, symbol errors, length errors, overlong frames, jabbers, fragments, undersized frames and jumbo frames and octets. A frame-status source raises one strobe per counter that the frame affects. Octet counters add the frame length given with the strobe. All other counters add one.

The host sees the bank through a narrow 16-bit register port. A write to the control word does one of two things. It can freeze every live counter into a shadow copy in a single cycle, so that a read over several words gives a consistent value. It can also zero the whole bank. Each shadow is read as three words. A 64-bit rollover bitmap records which counters have wrapped. Each word of the bitmap clears when it is read, which lets the host extend the counts in software by polling.

Top module: `stat_bank`

## Requirements
- R1: Each cycle with `evt_i[n]` high adds one to live counter n. For the octet counters (indices 0, 14, 15 and 23 by default), it adds `len_i` instead.
- R2: Counter n's shadow is read at address 0x40+4n. Slot +0 returns bits 15:0, slot +1 returns bits 31:16, and slot +2 returns bits 39:32 in the low byte with the high byte zero. Read data appears on `reg_rdata_o` in the cycle after `reg_re_i`.
- R3: Writing the control word (address 0x00) with bit 0 set copies every live counter into its shadow in that cycle. Shadows then hold their value through later events until the next snapshot.
- R4: Live counters keep counting during a snapshot. An event in the snapshot cycle is counted in the live counter but is not part of that snapshot.
- R5: Writing the control word with bit 1 set zeroes every live counter and every rollover bit. If an event arrives in the same cycle as a clear, the clear wins.
- R6: When counter n wraps past its maximum, the count continues modulo 2^CNT_W. Rollover bit n%16 of the word at address 0x04+n/16 is set.
- R7: Reading a rollover word returns its bits and clears them, so a second read returns zero.
- R8: Reads of unmapped addresses return zero. These are 0x00-0x03, 0x08-0x3F, slot +3 of any counter, and counters at or above NUM_CNT.
- R9: After reset, all counters, shadows, rollover bits and read data are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | NUM_CNT | One event strobe per counter |
| len_i | input | LEN_W | Frame length in octets, added by the octet counters |
| reg_we_i | input | 1 | Host write strobe |
| reg_re_i | input | 1 | Host read strobe |
| reg_addr_i | input | 8 | Host register address |
| reg_wdata_i | input | 16 | Host write data |
| reg_rdata_o | output | 16 | Host read data, registered |

## Verification
A table of strobe patterns drives the bank. The patterns include lone strobes, dense masks, zero-length and maximum-length frames, and strobes that hit octet and frame counters together. This separates the add-length path from the add-one path and exposes any lane coupling. Directed cases then line up an event with a snapshot and an event with a clear, which tells snapshot timing and clear priority apart. A second instance with narrow 18-bit counters is driven past its wrap point. That case checks the modulo count, the bitmap position of two different counters, and the clear-on-read behaviour. Unmapped slots and indices are read after non-zero values exist nearby.

// File: rtl/stat_bank_pkg.sv
package stat_bank_pkg;
  localparam int unsigned REG_W      = 16;
  localparam int unsigned ADDR_W     = 8;
  localparam int unsigned ROLL_WORDS = 4;
  localparam int unsigned ROLL_BITS  = ROLL_WORDS * REG_W;
  localparam int unsigned SLICE_W    = 3 * REG_W;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = 8'h00;
  localparam logic [ADDR_W-1:0] ROLL_BASE = 8'h04;
  localparam logic [ADDR_W-1:0] CNT_BASE  = 8'h40;
  localparam int unsigned SNAP_BIT = 0;
  localparam int unsigned CLR_BIT  = 1;
endpackage

// File: rtl/stat_cnt_lane.sv
module stat_cnt_lane #(
  parameter int unsigned CNT_W = 40,
  parameter int unsigned INC_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             evt_i,
  input  logic [INC_W-1:0] inc_i,
  input  logic             snap_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] shadow_o,
  output logic             wrap_o
);
  typedef logic [CNT_W:0] sum_t;

  logic [CNT_W-1:0] cnt_q, shadow_q;
  sum_t             sum;

  assign sum      = sum_t'(cnt_q) + sum_t'(inc_i);
  assign wrap_o   = evt_i & ~clr_i & sum[CNT_W];
  assign shadow_o = shadow_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (evt_i)  cnt_q <= sum[CNT_W-1:0];
  end

  // snapshot takes pre-event value; live keeps counting
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      shadow_q <= '0;
    else if (snap_i)  shadow_q <= cnt_q;
  end

  // R5
  clr_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0);
  // R3
  snap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !snap_i |=> $stable(shadow_q));
  // R1
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!evt_i && !clr_i) |=> $stable(cnt_q));
  // R6
  wrap_small_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> cnt_q < sum_t'($past(inc_i)));
endmodule

// File: rtl/stat_rollover.sv
module stat_rollover
  import stat_bank_pkg::*;
#(
  parameter int unsigned NUM_CNT = 24
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_CNT-1:0]    wrap_i,
  input  logic                  clr_i,
  input  logic [ROLL_WORDS-1:0] rd_clr_i,
  output logic [ROLL_BITS-1:0]  bits_o
);
  logic [NUM_CNT-1:0] bits_q;

  // a wrap in the read cycle survives the read-clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bits_q <= '0;
    else if (clr_i) bits_q <= '0;
    else begin
      for (int k = 0; k < NUM_CNT; k++)
        bits_q[k] <= wrap_i[k] | (bits_q[k] & ~rd_clr_i[k / REG_W]);
    end
  end

  assign bits_o = ROLL_BITS'(bits_q);

  for (genvar k = 0; k < NUM_CNT; k++) begin : g_chk
    // R6
    wrap_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wrap_i[k] |=> bits_q[k]);
    // R7
    read_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_clr_i[k / REG_W] && !wrap_i[k]) |=> !bits_q[k]);
  end
endmodule

// File: rtl/stat_host_if.sv
module stat_host_if
  import stat_bank_pkg::*;
#(
  parameter int unsigned NUM_CNT = 24,
  parameter int unsigned CNT_W   = 40
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic                     re_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [REG_W-1:0]         wdata_i,
  input  logic [NUM_CNT*CNT_W-1:0] shadow_i,
  input  logic [ROLL_BITS-1:0]     roll_i,
  output logic                     snap_o,
  output logic                     clr_o,
  output logic [ROLL_WORDS-1:0]    roll_rd_o,
  output logic [REG_W-1:0]         rdata_o
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic              is_ctrl, is_roll, is_cnt, mapped;
  logic [ADDR_W-1:0] cnt_off;
  logic [IDX_W-1:0]  idx;
  logic [1:0]        slot;
  logic [SLICE_W-1:0] full;
  logic [REG_W-1:0]  rd_val, rdata_q;

  assign is_ctrl = addr_i == CTRL_ADDR;
  assign is_roll = addr_i[ADDR_W-1:2] == ROLL_BASE[ADDR_W-1:2];
  assign is_cnt  = addr_i >= CNT_BASE;
  assign cnt_off = addr_i - CNT_BASE;
  assign idx     = cnt_off[ADDR_W-1:2];
  assign slot    = addr_i[1:0];
  assign mapped  = is_roll | (is_cnt & (32'(idx) < NUM_CNT) & (slot != 2'd3));

  assign snap_o = we_i & is_ctrl & wdata_i[SNAP_BIT];
  assign clr_o  = we_i & is_ctrl & wdata_i[CLR_BIT];

  for (genvar w = 0; w < ROLL_WORDS; w++) begin : g_rd
    assign roll_rd_o[w] = re_i & is_roll & (slot == 2'(w));
  end

  always_comb begin
    full = '0;
    for (int i = 0; i < NUM_CNT; i++)
      if (32'(idx) == i) full = SLICE_W'(shadow_i[i*CNT_W +: CNT_W]);
  end

  always_comb begin
    rd_val = '0;
    if (is_roll) rd_val = roll_i[slot*REG_W +: REG_W];
    else if (is_cnt) begin
      case (slot)
        2'd0:    rd_val = full[REG_W-1:0];
        2'd1:    rd_val = full[2*REG_W-1:REG_W];
        2'd2:    rd_val = {8'h00, full[2*REG_W +: 8]};
        default: rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (re_i) rdata_q <= rd_val;
  end
  assign rdata_o = rdata_q;

  // R8
  unmapped_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && !mapped) |=> rdata_o == '0);
  // R7
  roll_rd_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(roll_rd_o));
  // R2
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_o));
endmodule

// File: rtl/stat_bank.sv
module stat_bank
  import stat_bank_pkg::*;
#(
  parameter int unsigned       NUM_CNT  = 24,
  parameter int unsigned       CNT_W    = 40,
  parameter int unsigned       LEN_W    = 14,
  parameter logic [NUM_CNT-1:0] OCT_MASK = 24'h80C001
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_CNT-1:0] evt_i,
  input  logic [LEN_W-1:0]   len_i,
  input  logic               reg_we_i,
  input  logic               reg_re_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [REG_W-1:0]   reg_wdata_i,
  output logic [REG_W-1:0]   reg_rdata_o
);
  logic                     snap, clr;
  logic [ROLL_WORDS-1:0]    roll_rd;
  logic [ROLL_BITS-1:0]     roll_bits;
  logic [NUM_CNT-1:0]       wrap;
  logic [NUM_CNT*CNT_W-1:0] shadow;

  for (genvar n = 0; n < NUM_CNT; n++) begin : g_lane
    logic [LEN_W-1:0] inc;
    if (OCT_MASK[n]) begin : g_oct
      assign inc = len_i;
    end else begin : g_frm
      assign inc = LEN_W'(1);
    end
    stat_cnt_lane #(.CNT_W(CNT_W), .INC_W(LEN_W)) lane_i (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .evt_i    (evt_i[n]),
      .inc_i    (inc),
      .snap_i   (snap),
      .clr_i    (clr),
      .shadow_o (shadow[n*CNT_W +: CNT_W]),
      .wrap_o   (wrap[n])
    );
  end

  stat_rollover #(.NUM_CNT(NUM_CNT)) roll_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wrap_i   (wrap),
    .clr_i    (clr),
    .rd_clr_i (roll_rd),
    .bits_o   (roll_bits)
  );

  stat_host_if #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W)) host_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i),
    .re_i      (reg_re_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .shadow_i  (shadow),
    .roll_i    (roll_bits),
    .snap_o    (snap),
    .clr_o     (clr),
    .roll_rd_o (roll_rd),
    .rdata_o   (reg_rdata_o)
  );

  // R9
  reset_rdata_chk: assert property (@(posedge clk_i) $rose(rst_ni) |-> reg_rdata_o == '0);
endmodule

// File: tb/stat_bank_tb_top.sv
module stat_bank_tb_top;
  localparam int NC = 24;
  localparam logic [NC-1:0] OCT = 24'h80C001;
  localparam logic [37:0] STIM [12] = '{
    {24'h000001, 14'd64},   {24'h00000E, 14'd100},  {24'h800000, 14'd1518},
    {24'h004001, 14'd9000}, {24'h00FFFF, 14'd72},   {24'hFF0000, 14'd1500},
    {24'h000020, 14'd0},    {24'h0A5A5A, 14'd300},  {24'h000000, 14'd999},
    {24'hFFFFFF, 14'd16383},{24'h400002, 14'd60},   {24'h008000, 14'd128}
  };

  logic clk = 0, rst_n = 0;
  logic [NC-1:0] evt = '0;
  logic [13:0] len = '0;
  logic we = 0, re = 0;
  logic [7:0] addr = '0;
  logic [15:0] wdata = '0, rdata, rdata_s;
  logic [63:0] mdl [NC];
  int total = 0, fails = 0;

  always #10 clk = ~clk;

  stat_bank dut_i (.clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .len_i(len),
    .reg_we_i(we), .reg_re_i(re), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata));
  stat_bank #(.CNT_W(18)) dut_small_i (.clk_i(clk), .rst_ni(rst_n), .evt_i(evt),
    .len_i(len), .reg_we_i(we), .reg_re_i(re), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata_s));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic mdl_add(input logic [NC-1:0] e, input logic [13:0] l);
    for (int i = 0; i < NC; i++)
      if (e[i]) mdl[i] = (mdl[i] + (OCT[i] ? 64'(l) : 64'd1)) & 64'hFF_FFFF_FFFF;
  endtask

  task automatic mdl_clr();
    for (int i = 0; i < NC; i++) mdl[i] = '0;
  endtask

  task automatic pulse(input logic [NC-1:0] e, input logic [13:0] l);
    @(negedge clk); evt = e; len = l;
    @(negedge clk); evt = '0;
    mdl_add(e, l);
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d, input logic [NC-1:0] e);
    @(negedge clk); we = 1; addr = a; wdata = d; evt = e; len = 14'd5;
    @(negedge clk); we = 0; evt = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] vb, output logic [15:0] vs);
    @(negedge clk); re = 1; addr = a;
    @(negedge clk); re = 0;
    vb = rdata; vs = rdata_s;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [15:0] vb, vs;
    mdl_clr();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R9 reset state
    rd(8'h40, vb, vs); chk("R9 ctr0 lo", vb, 16'h0);
    rd(8'h42, vb, vs); chk("R9 ctr0 hi", vb, 16'h0);
    rd(8'h04, vb, vs); chk("R9 roll0", vb, 16'h0);
    // R1 R2 table walk
    for (int s = 0; s < 12; s++) pulse(STIM[s][37:14], STIM[s][13:0]);
    wr(8'h00, 16'h0001, '0);
    for (int i = 0; i < NC; i++) begin
      rd(8'(8'h40 + 4*i), vb, vs); chk($sformatf("R1 ctr%0d w0", i), vb, mdl[i][15:0]);
      rd(8'(8'h41 + 4*i), vb, vs); chk($sformatf("R1 ctr%0d w1", i), vb, mdl[i][31:16]);
      rd(8'(8'h42 + 4*i), vb, vs); chk($sformatf("R2 ctr%0d w2", i), vb, {8'h0, mdl[i][39:32]});
    end
    // R2 slice layout
    wr(8'h00, 16'h0002, '0); mdl_clr();
    for (int k = 0; k < 5; k++) pulse(24'h000003, 14'd16383);
    wr(8'h00, 16'h0001, '0);
    rd(8'h40, vb, vs); chk("R2 slice lo", vb, 16'h3FFB);
    rd(8'h41, vb, vs); chk("R2 slice mid", vb, 16'h0001);
    rd(8'h42, vb, vs); chk("R2 slice top", vb, 16'h0000);
    rd(8'h44, vb, vs); chk("R1 frame ctr", vb, 16'd5);
    // R3 shadow frozen
    for (int k = 0; k < 4; k++) pulse(24'h000002, 14'd1);
    rd(8'h44, vb, vs); chk("R3 frozen", vb, 16'd5);
    wr(8'h00, 16'h0001, '0);
    rd(8'h44, vb, vs); chk("R3 resnap", vb, 16'd9);
    // R4 event in snapshot cycle
    wr(8'h00, 16'h0001, 24'h000002);
    rd(8'h44, vb, vs); chk("R4 excl", vb, 16'd9);
    wr(8'h00, 16'h0001, '0);
    rd(8'h44, vb, vs); chk("R4 counted", vb, 16'd10);
    // R5 clear beats event
    wr(8'h00, 16'h0002, 24'h000002); mdl_clr();
    wr(8'h00, 16'h0001, '0);
    rd(8'h44, vb, vs); chk("R5 clr wins", vb, 16'd0);
    rd(8'h40, vb, vs); chk("R5 clr ctr0", vb, 16'd0);
    // R6 R7 wrap on narrow instance
    for (int k = 0; k < 17; k++) pulse(24'h800001, 14'd16383);
    wr(8'h00, 16'h0001, '0);
    rd(8'h40, vb, vs); chk("R6 mod lo", vs, 16'h3FEF); chk("R1 wide lo", vb, 16'h3FEF);
    rd(8'h41, vb, vs); chk("R6 mod mid", vs, 16'h0000); chk("R1 wide mid", vb, 16'h0004);
    rd(8'h04, vb, vs); chk("R6 roll w0", vs, 16'h0001); chk("R6 wide no roll", vb, 16'h0);
    rd(8'h05, vb, vs); chk("R6 roll w1", vs, 16'h0080);
    rd(8'h04, vb, vs); chk("R7 w0 cleared", vs, 16'h0000);
    rd(8'h05, vb, vs); chk("R7 w1 cleared", vs, 16'h0000);
    // R8 unmapped
    rd(8'h01, vb, vs); chk("R8 0x01", vb, 16'h0);
    rd(8'h08, vb, vs); chk("R8 0x08", vb, 16'h0);
    rd(8'h43, vb, vs); chk("R8 slot3", vb, 16'h0);
    rd(8'hA0, vb, vs); chk("R8 idx24", vb, 16'h0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule